// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the bus-write side of a byte-wide flash device and its array back end. It watches each accepted write (a 17-bit address plus one data byte) and recognises the multi-write unlock protocol. Every command opens with the same two-write key. A third write then selects byte program, ID-mode entry, ID-mode exit, or the long form. The long form adds a second key and a final write that picks chip erase, sector erase or boot-block lockout.

Each command that is recognised leaves the block as a single-cycle request. The block issues a program request with the target address and data, an erase request with a five-bit region mask, a lockout request, or an ID-mode enter or leave pulse. The block does not store the lockout state. The back end reports it on `boot_locked`. The block uses that input to drop program and sector-erase requests that target the boot region, and to keep the boot region out of a chip erase. While the back end reports that a chip erase is in progress, every write is ignored.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The key is data AAh to address 5555h, then data 55h to address 2AAAh. A write that does not match the expected address and data for the current step returns the decoder to idle, and no request is issued for that write.
- R2: Key, then A0h to 5555h, then one more write, makes `prog_req` high for exactly one cycle in the cycle after that fourth write. In that cycle `prog_addr` and `prog_data` carry the fourth write's address and data.
- R3: Key, 80h@5555h, key, 10h@5555h gives a chip erase. When `boot_locked` is low, `erase_req` pulses with `erase_mask` = 11111b.
- R4: When `boot_locked` is high, a chip erase pulses `erase_req` with `erase_mask` = 11110b, which leaves the boot region out.
- R5: Key, 80h@5555h, key, 30h to any address gives a sector erase. `erase_mask` is one-hot for the region that holds the address. Bit 0 is boot (00000h–03FFFh), bit 1 is parameter block 1 (04000h–05FFFh), bit 2 is parameter block 2 (06000h–07FFFh), bit 3 is main block 1 (08000h–0FFFFh), and bit 4 is main block 2 (10000h–1FFFFh).
- R6: A sector erase aimed at the boot region while `boot_locked` is high issues no request. The decoder returns to idle.
- R7: A program aimed at a boot-region address while `boot_locked` is high issues no request. Programs to other regions still go out.
- R8: Key, 80h@5555h, key, 40h@5555h pulses `lock_req`.
- R9: Key followed by 90h@5555h pulses `id_enter`.
- R10: `id_exit` pulses after the key followed by F0h@5555h. It also pulses after a single F0h write to any address while the decoder is idle.
- R11: While `chip_erase_busy` is high, writes are ignored. No request is issued, and the sequence state does not advance.
- R12: At most one request output is high in any cycle. A request is high only in the cycle after an accepted write.
- R13: Only the low 15 address bits are compared against 5555h and 2AAAh. For example, 1D555h serves as 5555h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| chip_erase_busy | input | 1 | Back end is running a chip erase |
| boot_locked | input | 1 | Boot-block lockout is active |
| prog_req | output | 1 | Program request pulse |
| prog_addr | output | 17 | Program target address |
| prog_data | output | 8 | Program data |
| erase_req | output | 1 | Erase request pulse |
| erase_mask | output | 5 | Regions to erase (bit 0 boot … bit 4 main 2) |
| lock_req | output | 1 | Set-lockout request pulse |
| id_enter | output | 1 | Enter ID mode pulse |
| id_exit | output | 1 | Leave ID mode pulse |

## Verification
The bench builds the decoder with its default parameters: 17-bit addresses, 8-bit data, a 15-bit unlock compare, and the bottom-boot region bases. With those values, every region edge in the 128K map can be reached with real addresses. The unlock addresses can also be aliased through bit 15 and bit 16. The bench models the back end's lockout flag and busy flag directly. This lets it reach the locked and unlocked variants of every erase and program command, and the ignored writes during a chip erase.

// File: rtl/flash_cmd_pkg.sv
// Package: shared constants and types for the flash command decoder.
// Assumes byte-wide data; command codes are fixed by the bus protocol.
package flash_cmd_pkg;

    localparam int NREG = 5;          // boot, param1, param2, main1, main2

    localparam logic [7:0] KEY_A     = 8'hAA;
    localparam logic [7:0] KEY_B     = 8'h55;
    localparam logic [7:0] OP_PROG   = 8'hA0;
    localparam logic [7:0] OP_LONG   = 8'h80;
    localparam logic [7:0] OP_ID_IN  = 8'h90;
    localparam logic [7:0] OP_ID_OUT = 8'hF0;
    localparam logic [7:0] OP_CHIP   = 8'h10;
    localparam logic [7:0] OP_SECTOR = 8'h30;
    localparam logic [7:0] OP_LOCK   = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE, ST_K1, ST_K2, ST_PROG, ST_L1, ST_L2, ST_L3
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_PROG, CMD_CHIP, CMD_SECTOR, CMD_LOCK, CMD_ID_IN, CMD_ID_OUT
    } cmd_t;

endpackage

// File: rtl/flash_seq_fsm.sv
// Module: flash_seq_fsm
// Tracks the unlock/command write sequence and names the command that the
// current write completes. Assumes wr_ok is already gated by busy.
// Any mismatching write returns to idle.
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int CMP_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output cmd_t              cmd
);
    localparam logic [CMP_W-1:0] ADDR_K5 = CMP_W'(17'h05555);
    localparam logic [CMP_W-1:0] ADDR_K2 = CMP_W'(17'h02AAA);

    seq_state_t state, state_nx;
    logic       at5, at2;

    assign at5 = (addr[CMP_W-1:0] == ADDR_K5);
    assign at2 = (addr[CMP_W-1:0] == ADDR_K2);

    // Next state and completed command for the current write
    always_comb begin
        state_nx = state;
        cmd      = CMD_NONE;
        if (wr_ok) begin
            state_nx = ST_IDLE;
            unique case (state)
                ST_IDLE: begin
                    if (at5 && data == KEY_A)   state_nx = ST_K1;
                    else if (data == OP_ID_OUT) cmd = CMD_ID_OUT;
                end
                ST_K1: if (at2 && data == KEY_B) state_nx = ST_K2;
                ST_K2: if (at5) begin
                    if (data == OP_PROG)        state_nx = ST_PROG;
                    else if (data == OP_LONG)   state_nx = ST_L1;
                    else if (data == OP_ID_IN)  cmd = CMD_ID_IN;
                    else if (data == OP_ID_OUT) cmd = CMD_ID_OUT;
                end
                ST_PROG: cmd = CMD_PROG;
                ST_L1: if (at5 && data == KEY_A) state_nx = ST_L2;
                ST_L2: if (at2 && data == KEY_B) state_nx = ST_L3;
                ST_L3: begin
                    if (data == OP_SECTOR)            cmd = CMD_SECTOR;
                    else if (at5 && data == OP_CHIP)  cmd = CMD_CHIP;
                    else if (at5 && data == OP_LOCK)  cmd = CMD_LOCK;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Sequence state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/flash_region_decode.sv
// Module: flash_region_decode
// Maps an address to a one-hot region mask. Assumes the bases are ascending
// and region 0 (boot) starts at address zero.
module flash_region_decode
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W  = 17,
    parameter logic [ADDR_W-1:0] P1_BASE = 17'h04000,
    parameter logic [ADDR_W-1:0] P2_BASE = 17'h06000,
    parameter logic [ADDR_W-1:0] M1_BASE = 17'h08000,
    parameter logic [ADDR_W-1:0] M2_BASE = 17'h10000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   mask
);
    localparam logic [ADDR_W-1:0] BASES [NREG] =
        '{'0, P1_BASE, P2_BASE, M1_BASE, M2_BASE};

    // One comparator window per region
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == NREG - 1) begin : g_last
            assign mask[i] = (addr >= BASES[i]);
        end else begin : g_mid
            assign mask[i] = (addr >= BASES[i]) && (addr < BASES[i+1]);
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: flash_cmd_decoder (top)
// Turns recognised write sequences into one-cycle requests for the array
// back end and applies boot-region protection. Assumes the back end owns
// the lockout flag and the chip-erase busy flag.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int CMP_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              chip_erase_busy,
    input  logic              boot_locked,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_req,
    output logic [NREG-1:0]   erase_mask,
    output logic              lock_req,
    output logic              id_enter,
    output logic              id_exit
);
    localparam logic [NREG-1:0] ALL_REG = '1;
    localparam logic [NREG-1:0] BOOT_REG = NREG'(1);

    logic            wr_ok;
    cmd_t            cmd;
    logic [NREG-1:0] region;
    logic            in_boot_locked;

    assign wr_ok          = wr_en && !chip_erase_busy;
    assign in_boot_locked = region[0] && boot_locked;

    flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
        .addr(wr_addr), .data(wr_data), .cmd(cmd)
    );

    flash_region_decode #(.ADDR_W(ADDR_W)) u_region (
        .addr(wr_addr), .mask(region)
    );

    // Request stage: one registered pulse per completed, permitted command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_req   <= 1'b0;
            prog_addr  <= '0;
            prog_data  <= '0;
            erase_req  <= 1'b0;
            erase_mask <= '0;
            lock_req   <= 1'b0;
            id_enter   <= 1'b0;
            id_exit    <= 1'b0;
        end else begin
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            lock_req  <= 1'b0;
            id_enter  <= 1'b0;
            id_exit   <= 1'b0;
            unique case (cmd)
                CMD_PROG: if (!in_boot_locked) begin
                    prog_req  <= 1'b1;
                    prog_addr <= wr_addr;
                    prog_data <= wr_data;
                end
                CMD_SECTOR: if (!in_boot_locked) begin
                    erase_req  <= 1'b1;
                    erase_mask <= region;
                end
                CMD_CHIP: begin
                    erase_req  <= 1'b1;
                    erase_mask <= boot_locked ? (ALL_REG & ~BOOT_REG) : ALL_REG;
                end
                CMD_LOCK:   lock_req <= 1'b1;
                CMD_ID_IN:  id_enter <= 1'b1;
                CMD_ID_OUT: id_exit  <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
// Module: flash_cmd_decoder_chk
// Checks the request outputs of flash_cmd_decoder against its inputs over
// time. It is attached to the top module by the bind below.
module flash_cmd_decoder_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              chip_erase_busy,
    input logic              boot_locked,
    input logic              prog_req,
    input logic [ADDR_W-1:0] prog_addr,
    input logic              erase_req,
    input logic [4:0]        erase_mask,
    input logic              lock_req,
    input logic              id_enter,
    input logic              id_exit
);
    localparam logic [ADDR_W-1:0] BOOT_END = 17'h04000;

    logic any_req;
    assign any_req = prog_req | erase_req | lock_req | id_enter | id_exit;

    // R12
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_req, lock_req, id_enter, id_exit}));

    // R12
    req_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> $past(wr_en));

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chip_erase_busy) |-> !any_req);

    // R4
    locked_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && $past(boot_locked)) |-> !erase_mask[0]);

    // R7
    locked_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && $past(boot_locked)) |-> (prog_addr >= BOOT_END));

    // R5
    erase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (erase_mask != 5'b0));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .chip_erase_busy(chip_erase_busy),
    .boot_locked(boot_locked), .prog_req(prog_req), .prog_addr(prog_addr),
    .erase_req(erase_req), .erase_mask(erase_mask), .lock_req(lock_req),
    .id_enter(id_enter), .id_exit(id_exit)
);

// File: tb/sim_flash_cmd_decoder.sv
// Directed bench for flash_cmd_decoder: one task per scenario.
module sim_flash_cmd_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        chip_erase_busy = 1'b0;
    logic        boot_locked = 1'b0;
    logic        prog_req, erase_req, lock_req, id_enter, id_exit;
    logic [16:0] prog_addr;
    logic [7:0]  prog_data;
    logic [4:0]  erase_mask;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .chip_erase_busy(chip_erase_busy),
        .boot_locked(boot_locked), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_req(erase_req), .erase_mask(erase_mask),
        .lock_req(lock_req), .id_enter(id_enter), .id_exit(id_exit)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Vector of request outputs: {prog, erase, lock, enter, exit}
    function automatic logic [4:0] reqs();
        return {prog_req, erase_req, lock_req, id_enter, id_exit};
    endfunction

    // One bus write; returns at the negedge where its result is visible
    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic key();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
    endtask

    task automatic long_pre();
        key();
        wr(17'h05555, 8'h80);
        key();
    endtask

    task automatic t_reset();
        check("R12 reset reqs", 32'(reqs()), 32'h0);
        check("R12 reset mask", 32'(erase_mask), 32'h0);
    endtask

    task automatic t_program();
        key();
        wr(17'h05555, 8'hA0);
        check("R2 no req before data", 32'(reqs()), 32'h0);
        wr(17'h0ABCD, 8'h3C);
        check("R2 prog pulse", 32'(reqs()), 32'b10000);
        check("R2 prog addr", 32'(prog_addr), 32'h0ABCD);
        check("R2 prog data", 32'(prog_data), 32'h3C);
        @(negedge clk);
        check("R2 one cycle", 32'(prog_req), 32'h0);
    endtask

    task automatic t_mismatch();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h56);
        wr(17'h05555, 8'hA0);
        wr(17'h09000, 8'h12);
        check("R1 broken key no req", 32'(reqs()), 32'h0);
    endtask

    task automatic t_alias();
        wr(17'h1D555, 8'hAA);
        wr(17'h0AAAA, 8'h55);
        wr(17'h0D555, 8'hA0);
        wr(17'h12345, 8'h5A);
        check("R13 aliased key prog", 32'(reqs()), 32'b10000);
        check("R13 prog addr", 32'(prog_addr), 32'h12345);
    endtask

    task automatic t_chip_unlocked();
        long_pre();
        wr(17'h05555, 8'h10);
        check("R3 chip erase req", 32'(reqs()), 32'b01000);
        check("R3 chip mask", 32'(erase_mask), 32'h1F);
    endtask

    task automatic sector(input logic [16:0] a, input logic [4:0] m, input logic hit);
        long_pre();
        wr(a, 8'h30);
        check("R5 sector req", 32'(erase_req), 32'(hit));
        if (hit) check("R5 sector mask", 32'(erase_mask), 32'(m));
    endtask

    task automatic t_sectors();
        sector(17'h01000, 5'b00001, 1'b1);
        sector(17'h04000, 5'b00010, 1'b1);
        sector(17'h07FFF, 5'b00100, 1'b1);
        sector(17'h08000, 5'b01000, 1'b1);
        sector(17'h1FFFF, 5'b10000, 1'b1);
    endtask

    task automatic t_lock();
        long_pre();
        wr(17'h05555, 8'h40);
        check("R8 lock req", 32'(reqs()), 32'b00100);
    endtask

    task automatic t_locked();
        boot_locked = 1'b1;
        long_pre();
        wr(17'h03FFF, 8'h30);
        check("R6 locked boot sector none", 32'(reqs()), 32'h0);
        wr(17'h09000, 8'h12);
        check("R6 back to idle", 32'(reqs()), 32'h0);
        long_pre();
        wr(17'h05555, 8'h10);
        check("R4 locked chip req", 32'(erase_req), 32'h1);
        check("R4 locked chip mask", 32'(erase_mask), 32'h1E);
        key(); wr(17'h05555, 8'hA0); wr(17'h02000, 8'h00);
        check("R7 locked boot prog none", 32'(reqs()), 32'h0);
        key(); wr(17'h05555, 8'hA0); wr(17'h04010, 8'h77);
        check("R7 other region prog", 32'(prog_req), 32'h1);
        check("R7 other region addr", 32'(prog_addr), 32'h04010);
        sector(17'h06000, 5'b00100, 1'b1);
        boot_locked = 1'b0;
    endtask

    task automatic t_id();
        key(); wr(17'h05555, 8'h90);
        check("R9 id enter", 32'(reqs()), 32'b00010);
        key(); wr(17'h05555, 8'hF0);
        check("R10 id exit long", 32'(reqs()), 32'b00001);
        wr(17'h13579, 8'hF0);
        check("R10 id exit single", 32'(reqs()), 32'b00001);
    endtask

    task automatic t_busy();
        chip_erase_busy = 1'b1;
        key(); wr(17'h05555, 8'hA0); wr(17'h09000, 8'h11);
        check("R11 busy prog none", 32'(reqs()), 32'h0);
        wr(17'h00000, 8'hF0);
        check("R11 busy exit none", 32'(reqs()), 32'h0);
        chip_erase_busy = 1'b0;
        wr(17'h09000, 8'h22);
        check("R11 state held idle", 32'(reqs()), 32'h0);
        key(); wr(17'h05555, 8'hA0); wr(17'h09000, 8'h33);
        check("R11 prog after busy", 32'(prog_req), 32'h1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_mismatch();
        t_alias();
        t_chip_unlocked();
        t_sectors();
        t_lock();
        t_locked();
        t_id();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule